// File: doc/BRIEF.md
# Receive Mailbox Lock Controller

This block guards an array of CAN receive mailboxes against a frame landing in a mailbox while the CPU is part-way through reading it. Reading a mailbox's code word has a side effect: if the mailbox holds a frame, the controller remembers that mailbox as locked. A later timer read, a code-word read of a different mailbox, or a code-word write to the locked mailbox drops the lock again. Only one mailbox is locked at a time.

Frames arrive from an acceptance filter as a target index plus a payload. A frame for an unlocked mailbox is stored at once. A frame for the locked mailbox is parked in a one-entry staging register. A later frame for the same place simply replaces the parked one, and nothing records the loss. Once the lock is gone, the parked frame is copied in over a fixed number of cycles. During that copy the mailbox's code shows a busy bit, and a read that sees the busy bit never locks.

The CPU side is a single access port. The strobes for write, read and timer read are resolved in that priority if several are raised together. A read returns the mailbox's visible code and payload one cycle after the strobe.

Top module: `rx_mb_lock_ctrl`

## Requirements
- R1: After reset every mailbox code is INACTIVE (4'b0000), every payload is zero, and `lock_vld` is 0.
- R2: A code read (`cpu_rd`) of a mailbox whose visible code is FULL (4'b0010) or OVERRUN (4'b0110) sets `lock_vld` and puts that index on `lock_idx` from the next cycle. The same edge loads `rd_code` and `rd_frame` with that mailbox's visible code and payload.
- R3: A read never sets the lock in four cases: the code is INACTIVE (4'b0000), the code has bit 3 set (a transmit code), the code has bit 0 (BUSY) set, or `fifo_en` is 1 and the index is below `FIFO_MBS`.
- R4: A read of an EMPTY (4'b0100) mailbox locks it when `empty_nolock` is 0, and does not lock it when `empty_nolock` is 1.
- R5: A timer read (`tmr_rd`) clears `lock_vld` on the next cycle.
- R6: A read of a mailbox other than the locked one releases the lock whatever that mailbox's code is. If that mailbox itself qualifies under R2/R4, the lock moves to it.
- R7: A code write (`cpu_wr`) to the locked mailbox releases the lock and stores `cpu_wcode`. A write to any other mailbox leaves the lock as it was.
- R8: A matched frame for a mailbox that is neither locked nor already targeted by the staging register is stored on the next edge. Its code becomes OVERRUN if the stored code was FULL or OVERRUN, and FULL otherwise.
- R9: A matched frame for the locked mailbox is held back. While the lock lasts, the mailbox's code and payload stay as they were, and a mailbox under a move-in is never the locked one.
- R10: A further frame for a mailbox whose frame is still staged replaces the staged frame. Only the newest frame lands, with the same code it would get had it been the only one staged.
- R11: Once the target is unlocked, BUSY (code bit 0) is visible on it for exactly `MOVE_CYC` cycles, starting in the cycle right after the unlock. The frame and its R8 code appear after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Code-word read strobe for mailbox `cpu_idx` |
| cpu_wr | input | 1 | Code-word write strobe for mailbox `cpu_idx` |
| cpu_idx | input | IDX_W | Mailbox addressed by the CPU |
| cpu_wcode | input | 4 | Code written by `cpu_wr` |
| tmr_rd | input | 1 | Free-running timer read strobe (global unlock) |
| fifo_en | input | 1 | Mailboxes below `FIFO_MBS` belong to the receive FIFO |
| empty_nolock | input | 1 | 1: EMPTY mailboxes are not locked by a read |
| match_vld | input | 1 | Acceptance filter delivers a frame this cycle |
| match_idx | input | IDX_W | Target mailbox of the delivered frame |
| match_frame | input | FRAME_W | Frame payload |
| rd_code | output | 4 | Visible code returned by the last read |
| rd_frame | output | FRAME_W | Payload returned by the last read |
| lock_vld | output | 1 | A mailbox is locked |
| lock_idx | output | IDX_W | Index of the locked mailbox |

## Verification
The hard case to reach is a staged frame that is replaced while it waits and then moved into a mailbox. The stimulus builds it in steps. It arms a mailbox, fills it, and locks it by reading it. Two more frames are sent to it while it is locked. The mailbox is then released by writing EMPTY. Back-to-back reads then sample the code on every cycle of the move, which shows exactly how long BUSY lasts, that those reads do not lock, and that only the last frame lands with a FULL code.

// File: rtl/mbl_pkg.sv
package mbl_pkg;

    localparam logic [3:0] CODE_INACTIVE = 4'b0000;
    localparam logic [3:0] CODE_EMPTY    = 4'b0100;
    localparam logic [3:0] CODE_FULL     = 4'b0010;
    localparam logic [3:0] CODE_OVERRUN  = 4'b0110;
    localparam int         BUSY_BIT      = 0;
    localparam int         TX_BIT        = 3;

    // Resolved CPU access for one cycle
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2,
        ACC_TMR  = 2'd3
    } acc_e;

    // Does a read of this visible code take the lock
    function automatic logic lock_ok(input logic [3:0] c, input logic empty_nolock);
        if (c[TX_BIT] || c[BUSY_BIT]) return 1'b0;
        return (c == CODE_FULL) || (c == CODE_OVERRUN) ||
               ((c == CODE_EMPTY) && !empty_nolock);
    endfunction

    // Code left behind when a frame lands on a mailbox holding code prev
    function automatic logic [3:0] land_code(input logic [3:0] prev);
        return ((prev == CODE_FULL) || (prev == CODE_OVERRUN)) ? CODE_OVERRUN : CODE_FULL;
    endfunction

endpackage

// File: rtl/mbl_lock_track.sv
module mbl_lock_track
    import mbl_pkg::*;
#(
    parameter int NUM_MB   = 8,
    parameter int FIFO_MBS = 2,
    localparam int IDX_W   = $clog2(NUM_MB)
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_e             acc,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [3:0]       acc_code,
    input  logic             fifo_en,
    input  logic             empty_nolock,
    output logic             lock_vld,
    output logic [IDX_W-1:0] lock_idx
);

    localparam logic [IDX_W:0] FIFO_LIM = (IDX_W+1)'(FIFO_MBS);

    logic in_fifo;
    logic can_lock;

    assign in_fifo  = fifo_en && ({1'b0, acc_idx} < FIFO_LIM);
    assign can_lock = !in_fifo && lock_ok(acc_code, empty_nolock);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_vld <= 1'b0;
            lock_idx <= '0;
        end else begin
            unique case (acc)
                ACC_WR: begin
                    if (acc_idx == lock_idx) lock_vld <= 1'b0;
                end
                ACC_RD: begin
                    lock_vld <= can_lock;
                    if (can_lock) lock_idx <= acc_idx;
                end
                ACC_TMR: lock_vld <= 1'b0;
                default: ;
            endcase
        end
    end

    // R5
    tmr_release_chk: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_TMR) |=> !lock_vld);

    // R7
    wr_release_chk: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_WR && lock_vld && acc_idx == lock_idx) |=> !lock_vld);

    // R2
    lock_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_vld) |-> ($past(acc) == ACC_RD && lock_idx == $past(acc_idx)));

    // R3
    busy_nolock_chk: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_RD && acc_code[BUSY_BIT]) |=> !lock_vld);

endmodule

// File: rtl/mbl_stage.sv
module mbl_stage
    import mbl_pkg::*;
#(
    parameter int NUM_MB   = 8,
    parameter int FRAME_W  = 32,
    parameter int MOVE_CYC = 4,
    localparam int IDX_W   = $clog2(NUM_MB),
    localparam int CNT_W   = $clog2(MOVE_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               match_vld,
    input  logic [IDX_W-1:0]   match_idx,
    input  logic [FRAME_W-1:0] match_frame,
    input  logic               lock_vld,
    input  logic [IDX_W-1:0]   lock_idx,
    output logic               dir_we,
    output logic               land_we,
    output logic [IDX_W-1:0]   land_idx,
    output logic [FRAME_W-1:0] land_frame,
    output logic               busy_vld
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MOVE_CYC - 1);

    logic               stg_vld;
    logic [IDX_W-1:0]   stg_idx;
    logic [FRAME_W-1:0] stg_frame;
    logic [CNT_W-1:0]   cnt;
    logic               need_stage;

    // A move runs whenever a frame is staged and its target is free
    assign busy_vld   = stg_vld && !(lock_vld && lock_idx == stg_idx);
    assign land_we    = busy_vld && (cnt == LAST);
    assign land_idx   = stg_idx;
    assign land_frame = stg_frame;

    assign need_stage = (lock_vld && match_idx == lock_idx) ||
                        (stg_vld && match_idx == stg_idx);
    assign dir_we     = match_vld && !need_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_vld   <= 1'b0;
            stg_idx   <= '0;
            stg_frame <= '0;
            cnt       <= '0;
        end else begin
            if (land_we) begin
                stg_vld <= 1'b0;
                cnt     <= '0;
            end else if (busy_vld) begin
                cnt <= cnt + 1'b1;
            end
            if (match_vld && need_stage) begin
                stg_vld   <= 1'b1;
                stg_idx   <= match_idx;
                stg_frame <= match_frame;
                if (!stg_vld || match_idx != stg_idx) cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/mbl_mb_array.sv
module mbl_mb_array
    import mbl_pkg::*;
#(
    parameter int NUM_MB  = 8,
    parameter int FRAME_W = 32,
    localparam int IDX_W  = $clog2(NUM_MB)
) (
    input  logic               clk,
    input  logic               rst,
    input  acc_e               acc,
    input  logic [IDX_W-1:0]   acc_idx,
    input  logic [3:0]         wcode,
    input  logic               dir_we,
    input  logic [IDX_W-1:0]   dir_idx,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic               land_we,
    input  logic [IDX_W-1:0]   land_idx,
    input  logic [FRAME_W-1:0] land_frame,
    input  logic               busy_vld,
    input  logic [IDX_W-1:0]   busy_idx,
    output logic [3:0]         acc_code,
    output logic [3:0]         rd_code,
    output logic [FRAME_W-1:0] rd_frame
);

    logic [3:0]         code_q  [NUM_MB];
    logic [FRAME_W-1:0] frame_q [NUM_MB];
    logic [3:0]         vis     [NUM_MB];

    for (genvar g = 0; g < NUM_MB; g++) begin : g_vis
        assign vis[g] = code_q[g] | {3'b000, busy_vld && (busy_idx == IDX_W'(g))};
    end

    assign acc_code = vis[acc_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_MB; i++) begin
                code_q[i]  <= CODE_INACTIVE;
                frame_q[i] <= '0;
            end
            rd_code  <= '0;
            rd_frame <= '0;
        end else begin
            if (acc == ACC_WR) code_q[acc_idx] <= wcode;
            if (dir_we) begin
                frame_q[dir_idx] <= dir_frame;
                code_q[dir_idx]  <= land_code(code_q[dir_idx]);
            end
            if (land_we) begin
                frame_q[land_idx] <= land_frame;
                code_q[land_idx]  <= land_code(code_q[land_idx]);
            end
            if (acc == ACC_RD) begin
                rd_code  <= vis[acc_idx];
                rd_frame <= frame_q[acc_idx];
            end
        end
    end

endmodule

// File: rtl/rx_mb_lock_ctrl.sv
module rx_mb_lock_ctrl
    import mbl_pkg::*;
#(
    parameter int NUM_MB   = 8,
    parameter int FRAME_W  = 32,
    parameter int FIFO_MBS = 2,
    parameter int MOVE_CYC = 4,
    localparam int IDX_W   = $clog2(NUM_MB)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [IDX_W-1:0]   cpu_idx,
    input  logic [3:0]         cpu_wcode,
    input  logic               tmr_rd,
    input  logic               fifo_en,
    input  logic               empty_nolock,
    input  logic               match_vld,
    input  logic [IDX_W-1:0]   match_idx,
    input  logic [FRAME_W-1:0] match_frame,
    output logic [3:0]         rd_code,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               lock_vld,
    output logic [IDX_W-1:0]   lock_idx
);

    acc_e               acc;
    logic [3:0]         acc_code;
    logic               dir_we;
    logic               land_we;
    logic [IDX_W-1:0]   land_idx;
    logic [FRAME_W-1:0] land_frame;
    logic               busy_vld;

    assign acc = cpu_wr ? ACC_WR : cpu_rd ? ACC_RD : tmr_rd ? ACC_TMR : ACC_NONE;

    mbl_lock_track #(.NUM_MB(NUM_MB), .FIFO_MBS(FIFO_MBS)) u_lock (
        .clk(clk), .rst(rst), .acc(acc), .acc_idx(cpu_idx), .acc_code(acc_code),
        .fifo_en(fifo_en), .empty_nolock(empty_nolock),
        .lock_vld(lock_vld), .lock_idx(lock_idx)
    );

    mbl_stage #(.NUM_MB(NUM_MB), .FRAME_W(FRAME_W), .MOVE_CYC(MOVE_CYC)) u_stage (
        .clk(clk), .rst(rst), .match_vld(match_vld), .match_idx(match_idx),
        .match_frame(match_frame), .lock_vld(lock_vld), .lock_idx(lock_idx),
        .dir_we(dir_we), .land_we(land_we), .land_idx(land_idx),
        .land_frame(land_frame), .busy_vld(busy_vld)
    );

    mbl_mb_array #(.NUM_MB(NUM_MB), .FRAME_W(FRAME_W)) u_array (
        .clk(clk), .rst(rst), .acc(acc), .acc_idx(cpu_idx), .wcode(cpu_wcode),
        .dir_we(dir_we), .dir_idx(match_idx), .dir_frame(match_frame),
        .land_we(land_we), .land_idx(land_idx), .land_frame(land_frame),
        .busy_vld(busy_vld), .busy_idx(land_idx), .acc_code(acc_code),
        .rd_code(rd_code), .rd_frame(rd_frame)
    );

    // R8
    direct_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        dir_we |-> !(lock_vld && match_idx == lock_idx));

    // R9
    moving_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        lock_vld |-> !(busy_vld && land_idx == lock_idx));

endmodule

// File: tb/tb_rx_mb_lock_ctrl.sv
module tb_rx_mb_lock_ctrl;

    localparam int OP_IDLE = 0, OP_RD = 1, OP_WR = 2, OP_TMR = 3;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_rd = 0, cpu_wr = 0, tmr_rd = 0, fifo_en = 0, empty_nolock = 1;
    logic [2:0]  cpu_idx = 0, match_idx = 0;
    logic [3:0]  cpu_wcode = 0;
    logic        match_vld = 0;
    logic [31:0] match_frame = 0;
    logic [3:0]  rd_code;
    logic [31:0] rd_frame;
    logic        lock_vld;
    logic [2:0]  lock_idx;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    rx_mb_lock_ctrl dut (
        .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_idx(cpu_idx),
        .cpu_wcode(cpu_wcode), .tmr_rd(tmr_rd), .fifo_en(fifo_en),
        .empty_nolock(empty_nolock), .match_vld(match_vld), .match_idx(match_idx),
        .match_frame(match_frame), .rd_code(rd_code), .rd_frame(rd_frame),
        .lock_vld(lock_vld), .lock_idx(lock_idx)
    );

    // {op[1:0], idx[2:0], val[3:0], exp_lock, exp_idx[2:0], check_code}
    localparam logic [13:0] VEC [NV] = '{
        {2'd1, 3'd3, 4'h0, 1'b1, 3'd3, 1'b1},
        {2'd1, 3'd3, 4'h0, 1'b1, 3'd3, 1'b1},
        {2'd1, 3'd5, 4'h0, 1'b1, 3'd5, 1'b1},
        {2'd1, 3'd6, 4'h0, 1'b0, 3'd0, 1'b1},
        {2'd1, 3'd4, 4'h0, 1'b1, 3'd4, 1'b1},
        {2'd3, 3'd0, 4'h0, 1'b0, 3'd0, 1'b0},
        {2'd1, 3'd4, 4'h0, 1'b1, 3'd4, 1'b1},
        {2'd2, 3'd3, 4'h2, 1'b1, 3'd4, 1'b0},
        {2'd1, 3'd0, 4'h0, 1'b0, 3'd0, 1'b1},
        {2'd1, 3'd4, 4'h0, 1'b1, 3'd4, 1'b1},
        {2'd1, 3'd7, 4'h0, 1'b0, 3'd0, 1'b1},
        {2'd1, 3'd4, 4'h0, 1'b1, 3'd4, 1'b1},
        {2'd2, 3'd4, 4'h6, 1'b0, 3'd0, 1'b0},
        {2'd1, 3'd1, 4'h0, 1'b1, 3'd1, 1'b1}
    };
    localparam logic [3:0] VCODE [NV] = '{
        4'h2, 4'h2, 4'h2, 4'h4, 4'h6, 4'h0, 4'h6,
        4'h0, 4'h0, 4'h6, 4'hC, 4'h6, 4'h0, 4'h2
    };
    string vtag [NV] = '{"R2", "R2", "R6", "R6/R4", "R2", "R5", "R2",
                         "R7", "R3/R6", "R2", "R3", "R2", "R7", "R6"};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One access, consuming exactly one rising edge
    task automatic op(input int k, input int ix, input logic [3:0] v);
        cpu_rd  = (k == OP_RD);
        cpu_wr  = (k == OP_WR);
        tmr_rd  = (k == OP_TMR);
        cpu_idx = ix[2:0];
        cpu_wcode = v;
        @(posedge clk);
        #1;
        cpu_rd = 0; cpu_wr = 0; tmr_rd = 0;
    endtask

    task automatic send(input int ix, input logic [31:0] fr);
        match_vld = 1; match_idx = ix[2:0]; match_frame = fr;
        @(posedge clk);
        #1;
        match_vld = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        chk("R1 lock", {31'b0, lock_vld}, 0);
        op(OP_RD, 2, 0);
        chk("R1 code", {28'b0, rd_code}, 0);
        chk("R1 frame", rd_frame, 0);
        chk("R1 lock after read", {31'b0, lock_vld}, 0);
        op(OP_RD, 7, 0);
        chk("R1 code mb7", {28'b0, rd_code}, 0);

        // setup codes
        op(OP_WR, 3, 4'h2); op(OP_WR, 5, 4'h2); op(OP_WR, 6, 4'h4);
        op(OP_WR, 1, 4'h2); op(OP_WR, 7, 4'hC); op(OP_WR, 4, 4'h6);

        for (int i = 0; i < NV; i++) begin
            op(int'(VEC[i][13:12]), int'(VEC[i][11:9]), VEC[i][8:5]);
            chk(vtag[i], {31'b0, lock_vld}, {31'b0, VEC[i][4]});
            if (VEC[i][4]) chk(vtag[i], {29'b0, lock_idx}, {29'b0, VEC[i][3:1]});
            if (VEC[i][0]) chk(vtag[i], {28'b0, rd_code}, {28'b0, VCODE[i]});
        end
        op(OP_TMR, 0, 0);
        chk("R5 tmr", {31'b0, lock_vld}, 0);

        // R3 FIFO mailboxes never lock
        fifo_en = 1;
        op(OP_RD, 1, 0);
        chk("R3 fifo", {31'b0, lock_vld}, 0);
        fifo_en = 0;
        op(OP_RD, 1, 0);
        chk("R3 fifo off", {31'b0, lock_vld}, 1);
        op(OP_TMR, 0, 0);

        // R4 legacy empty locking
        empty_nolock = 0;
        op(OP_RD, 6, 0);
        chk("R4 empty lock", {31'b0, lock_vld}, 1);
        chk("R4 empty idx", {29'b0, lock_idx}, 6);
        op(OP_TMR, 0, 0);
        empty_nolock = 1;

        // R8 direct stores
        send(6, 32'hA0A0_0001);
        op(OP_RD, 6, 0);
        chk("R8 full code", {28'b0, rd_code}, 4'h2);
        chk("R8 frame", rd_frame, 32'hA0A0_0001);
        op(OP_TMR, 0, 0);
        send(6, 32'hB0B0_0002);
        op(OP_RD, 6, 0);
        chk("R8 overrun code", {28'b0, rd_code}, 4'h6);
        chk("R8 frame 2", rd_frame, 32'hB0B0_0002);
        op(OP_TMR, 0, 0);

        // R9/R10/R11 staging and move-in
        op(OP_WR, 2, 4'h4);
        send(2, 32'hC0C0_0003);
        op(OP_RD, 2, 0);
        chk("R9 lock", {31'b0, lock_vld}, 1);
        send(2, 32'hD0D0_0004);
        op(OP_RD, 2, 0);
        chk("R9 held code", {28'b0, rd_code}, 4'h2);
        chk("R9 held frame", rd_frame, 32'hC0C0_0003);
        send(2, 32'hE0E0_0005);
        op(OP_WR, 2, 4'h4);
        chk("R7 write release", {31'b0, lock_vld}, 0);
        for (int c = 0; c < 4; c++) begin
            op(OP_RD, 2, 0);
            chk("R11 busy", {28'b0, rd_code}, 4'h5);
            chk("R3 busy no lock", {31'b0, lock_vld}, 0);
        end
        op(OP_RD, 2, 0);
        chk("R11 landed code", {28'b0, rd_code}, 4'h2);
        chk("R10 newest frame", rd_frame, 32'hE0E0_0005);
        op(OP_TMR, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule